// File: doc/BRIEF.md
# Power Ramp Sequencer

This block shapes the transmit output level when a burst is switched. It produces a gain word. The gain is unity while the block is idle. On a request it walks a stored envelope downward, holds at the floor for a programmable number of samples, and then walks the envelope back up. It advances one step for each strobe from the filter output stage, so the envelope follows the sample rate and not the clock. The down ramp and the up ramp can have different lengths. Optional interpolation inserts the midpoint between each pair of neighbouring stored points, which doubles the smoothness of the envelope without extra storage.

Software sets up the block through a small register port and a separate coefficient write port. Ramp lengths, the rest interval and the interpolation choice are captured when a request is accepted, so software can prepare the next burst while a ramp is still running. The multiplier that applies the gain to the data path lies outside this block.

Top module: `pwr_ramp_seq`

## Requirements
- R1: After synchronous reset, busy and done are low, gain is unity (the value 2^(GAIN_W-1), which is 0x8000 for the default width), and every configuration field is zero.
- R2: When cfg_we is high, cfg_wdata is written to the field chosen by cfg_addr. Address 0 is control: bit 0 enables the ramp and bit 1 enables interpolation. Address 1 is the down length, address 2 is the up length and address 3 is the rest count. Each length holds the number of stored points used minus one. When coef_we is high, coef_wdata is written to coefficient entry coef_addr.
- R3: While the ramp enable bit is clear, requests are ignored, busy stays low and gain settles to unity. Clearing the bit during a ramp returns the block to idle without a done pulse.
- R4: A ramp_req seen while idle and enabled raises busy at that edge and starts the down ramp at entry L (the down length). The gain word shows a new step two clock edges after the edge at which the step changes.
- R5: Without interpolation, the down ramp reads entries L, L-1, … 0, one step per strobe. The strobe after entry 0 starts the rest interval, which holds entry 0 for as many strobes as the rest count. A rest count of zero goes straight to the up ramp.
- R6: The up ramp reads entries 0, 1, … U, one step per strobe. The strobe after entry U returns the block to idle with unity gain, drops busy and pulses done high for exactly one clock.
- R7: An up length of zero makes the up ramp reuse the down length.
- R8: With interpolation on, a midpoint step is placed between every pair of adjacent entries. The midpoint equals floor((c[i]+c[i+1])/2).
- R9: A request that arrives while a ramp is in progress has no effect on the envelope.
- R10: The ramp position changes only on a strobe. Without strobes, gain and busy hold.
- R11: Lengths, the rest count and the interpolation choice are captured when a request is accepted. Writes made during a ramp affect only the next ramp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration field select |
| cfg_wdata | input | REST_W | Configuration write data |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | COEF_AW | Coefficient entry index |
| coef_wdata | input | GAIN_W | Coefficient value |
| smp_stb | input | 1 | One-clock strobe per filter output sample |
| ramp_req | input | 1 | Ramp start request |
| gain | output | GAIN_W | Registered gain word |
| busy | output | 1 | High from request acceptance until return to idle |
| done | output | 1 | One-clock pulse on return to idle |

## Verification
Some rules are checked on every cycle. Done is a single-clock pulse that follows a busy period. Busy can rise only after an enabled request. Busy cannot end without a strobe while the enable stays on. A cleared enable forces idle, and after three cycles the gain is unity. The exact gain values are checked only by the bench's scenarios. These cover the order in which coefficients are read, the rest hold, floor rounding of the midpoints, the fallback when the up length is zero, the capture of the configuration at request time, and requests that are ignored in the middle of a ramp.

// File: rtl/prs_pkg.sv
package prs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DOWN = 2'd1,
    ST_REST = 2'd2,
    ST_UP   = 2'd3
  } prs_state_e;

  localparam logic [1:0] CFG_CTRL = 2'd0;
  localparam logic [1:0] CFG_LDN  = 2'd1;
  localparam logic [1:0] CFG_LUP  = 2'd2;
  localparam logic [1:0] CFG_REST = 2'd3;
endpackage

// File: rtl/prs_cfg_regs.sv
module prs_cfg_regs
  import prs_pkg::*;
#(
  parameter int AW     = 4,
  parameter int REST_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [REST_W-1:0] cfg_wdata,
  output logic              ramp_en,
  output logic              interp_en,
  output logic [AW-1:0]     len_dn,
  output logic [AW-1:0]     len_up,
  output logic [REST_W-1:0] rest_cnt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ramp_en   <= 1'b0;
      interp_en <= 1'b0;
      len_dn    <= '0;
      len_up    <= '0;
      rest_cnt  <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        CFG_CTRL: begin
          ramp_en   <= cfg_wdata[0];
          interp_en <= cfg_wdata[1];
        end
        CFG_LDN:  len_dn   <= cfg_wdata[AW-1:0];
        CFG_LUP:  len_up   <= cfg_wdata[AW-1:0];
        default:  rest_cnt <= cfg_wdata;
      endcase
    end
  end
endmodule

// File: rtl/prs_coef_ram.sv
module prs_coef_ram #(
  parameter int AW  = 4,
  parameter int DW  = 16,
  parameter int NRD = 2
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DW-1:0]     wdata,
  input  logic [NRD*AW-1:0] raddr,
  output logic [NRD*DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  // One simple-dual-port copy per read port; all copies share the write.
  for (genvar g = 0; g < NRD; g++) begin : g_copy
    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rd_q;
    always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      rd_q <= mem[raddr[g*AW +: AW]];
    end
    assign rdata[g*DW +: DW] = rd_q;
  end
endmodule

// File: rtl/prs_seq_fsm.sv
module prs_seq_fsm
  import prs_pkg::*;
#(
  parameter int AW     = 4,
  parameter int REST_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ramp_en,
  input  logic              interp_en,
  input  logic [AW-1:0]     len_dn,
  input  logic [AW-1:0]     len_up,
  input  logic [REST_W-1:0] rest_cnt,
  input  logic              ramp_req,
  input  logic              smp_stb,
  output prs_state_e        state,
  output logic [AW:0]       pos,
  output logic              done
);
  localparam int PW = AW + 1;

  prs_state_e        st_q;
  logic [PW-1:0]     pos_q;
  logic [PW-1:0]     top_up_q;
  logic [REST_W-1:0] rest_q;
  logic [REST_W-1:0] cnt_q;
  logic              fine_q;
  logic [PW-1:0]     stride;

  // Position counts half steps; without interpolation it moves two at a time.
  assign stride = fine_q ? PW'(1) : PW'(2);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      pos_q    <= '0;
      top_up_q <= '0;
      rest_q   <= '0;
      cnt_q    <= '0;
      fine_q   <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!ramp_en) begin
        st_q  <= ST_IDLE;
        pos_q <= '0;
      end else begin
        case (st_q)
          ST_IDLE: if (ramp_req) begin
            st_q     <= ST_DOWN;
            pos_q    <= {len_dn, 1'b0};
            top_up_q <= (len_up != '0) ? {len_up, 1'b0} : {len_dn, 1'b0};
            rest_q   <= rest_cnt;
            fine_q   <= interp_en;
          end
          ST_DOWN: if (smp_stb) begin
            if (pos_q == '0) begin
              if (rest_q == '0) begin
                st_q <= ST_UP;
              end else begin
                st_q  <= ST_REST;
                cnt_q <= rest_q;
              end
            end else begin
              pos_q <= pos_q - stride;
            end
          end
          ST_REST: if (smp_stb) begin
            if (cnt_q == REST_W'(1)) st_q <= ST_UP;
            else                     cnt_q <= cnt_q - REST_W'(1);
          end
          default: if (smp_stb) begin
            if (pos_q == top_up_q) begin
              st_q  <= ST_IDLE;
              pos_q <= '0;
              done  <= 1'b1;
            end else begin
              pos_q <= pos_q + stride;
            end
          end
        endcase
      end
    end
  end

  assign state = st_q;
  assign pos   = pos_q;
endmodule

// File: rtl/prs_gain_path.sv
module prs_gain_path #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel_unity,
  input  logic          sel_mid,
  input  logic [DW-1:0] rd_a,
  input  logic [DW-1:0] rd_b,
  output logic [DW-1:0] gain
);
  localparam logic [DW-1:0] UNITY = {1'b1, {(DW-1){1'b0}}};

  logic          unity_q;
  logic          mid_q;
  logic [DW:0]   pair_sum;
  logic [DW-1:0] midpoint;

  assign pair_sum = {1'b0, rd_a} + {1'b0, rd_b};
  assign midpoint = pair_sum[DW:1];

  // Selects are delayed one clock to line up with the RAM read.
  always_ff @(posedge clk) begin
    if (rst) begin
      unity_q <= 1'b1;
      mid_q   <= 1'b0;
      gain    <= UNITY;
    end else begin
      unity_q <= sel_unity;
      mid_q   <= sel_mid;
      gain    <= unity_q ? UNITY : (mid_q ? midpoint : rd_a);
    end
  end
endmodule

// File: rtl/pwr_ramp_seq.sv
module pwr_ramp_seq
  import prs_pkg::*;
#(
  parameter int GAIN_W  = 16,
  parameter int COEF_AW = 4,
  parameter int REST_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_addr,
  input  logic [REST_W-1:0]  cfg_wdata,
  input  logic               coef_we,
  input  logic [COEF_AW-1:0] coef_addr,
  input  logic [GAIN_W-1:0]  coef_wdata,
  input  logic               smp_stb,
  input  logic               ramp_req,
  output logic [GAIN_W-1:0]  gain,
  output logic               busy,
  output logic               done
);
  logic               ramp_en;
  logic               interp_en;
  logic [COEF_AW-1:0] len_dn;
  logic [COEF_AW-1:0] len_up;
  logic [REST_W-1:0]  rest_cnt;
  prs_state_e         state;
  logic [COEF_AW:0]   pos;
  logic [COEF_AW-1:0] addr_a;
  logic [COEF_AW-1:0] addr_b;
  logic [2*GAIN_W-1:0] rd_pair;

  prs_cfg_regs #(.AW(COEF_AW), .REST_W(REST_W)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ramp_en(ramp_en), .interp_en(interp_en),
    .len_dn(len_dn), .len_up(len_up), .rest_cnt(rest_cnt)
  );

  prs_seq_fsm #(.AW(COEF_AW), .REST_W(REST_W)) u_fsm (
    .clk(clk), .rst(rst), .ramp_en(ramp_en), .interp_en(interp_en),
    .len_dn(len_dn), .len_up(len_up), .rest_cnt(rest_cnt),
    .ramp_req(ramp_req), .smp_stb(smp_stb),
    .state(state), .pos(pos), .done(done)
  );

  assign addr_a = pos[COEF_AW:1];
  assign addr_b = COEF_AW'(addr_a + 1'b1);

  prs_coef_ram #(.AW(COEF_AW), .DW(GAIN_W), .NRD(2)) u_ram (
    .clk(clk), .we(coef_we), .waddr(coef_addr), .wdata(coef_wdata),
    .raddr({addr_b, addr_a}), .rdata(rd_pair)
  );

  prs_gain_path #(.DW(GAIN_W)) u_gain (
    .clk(clk), .rst(rst),
    .sel_unity(state == ST_IDLE), .sel_mid(pos[0]),
    .rd_a(rd_pair[GAIN_W-1:0]), .rd_b(rd_pair[2*GAIN_W-1:GAIN_W]),
    .gain(gain)
  );

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/pwr_ramp_seq_chk.sv
module pwr_ramp_seq_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic          ramp_req,
  input logic          smp_stb,
  input logic          busy,
  input logic          done,
  input logic [DW-1:0] gain
);
  localparam logic [DW-1:0] UNITY = {1'b1, {(DW-1){1'b0}}};

  p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_ends_busy_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  p_start_on_request_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(ramp_req && en));

  p_hold_no_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && en && !smp_stb) |=> busy);

  p_off_forces_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !en |=> !busy);

  p_off_unity_gain_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(!en) && $past(!en, 2) && $past(!en, 3)) |-> (gain == UNITY));
endmodule

bind pwr_ramp_seq pwr_ramp_seq_chk #(.DW(GAIN_W)) u_chk (
  .clk(clk), .rst(rst), .en(ramp_en), .ramp_req(ramp_req),
  .smp_stb(smp_stb), .busy(busy), .done(done), .gain(gain)
);

// File: tb/pwr_ramp_seq_tb_top.sv
module pwr_ramp_seq_tb_top;
  localparam int DW = 16;
  localparam int AW = 4;
  localparam int RW = 8;
  localparam int UNITY = 32768;
  // interp, down len, up len, rest, strobes from request to done
  localparam int ROWS [5][5] = '{
    '{0, 3, 0, 2, 10},
    '{0, 2, 4, 0, 8},
    '{1, 2, 1, 1, 9},
    '{0, 0, 0, 0, 2},
    '{1, 3, 2, 3, 15}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst;
  logic          cfg_we;
  logic [1:0]    cfg_addr;
  logic [RW-1:0] cfg_wdata;
  logic          coef_we;
  logic [AW-1:0] coef_addr;
  logic [DW-1:0] coef_wdata;
  logic          smp_stb;
  logic          ramp_req;
  logic [DW-1:0] gain;
  logic          busy;
  logic          done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int coef_m [16];
  int exp_q [64];

  pwr_ramp_seq dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .coef_we(coef_we), .coef_addr(coef_addr),
    .coef_wdata(coef_wdata), .smp_stb(smp_stb), .ramp_req(ramp_req),
    .gain(gain), .busy(busy), .done(done)
  );

  task automatic chk(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic int cv(input int p);
    if (p % 2 == 0) return coef_m[p/2];
    return (coef_m[p/2] + coef_m[p/2+1]) / 2;
  endfunction

  task automatic build(input int interp, input int ld, input int lu, input int rest);
    int n = 0;
    int st = interp ? 1 : 2;
    int upl = (lu == 0) ? ld : lu;
    for (int i = 0; i < 64; i++) exp_q[i] = UNITY;
    for (int p = 2*ld; p >= 0; p -= st) begin exp_q[n] = cv(p); n++; end
    for (int r = 0; r < rest; r++) begin exp_q[n] = cv(0); n++; end
    for (int p = 0; p <= 2*upl; p += st) begin exp_q[n] = cv(p); n++; end
  endtask

  task automatic cfg_write(input logic [1:0] a, input int d);
    @(negedge clk) begin cfg_we = 1'b1; cfg_addr = a; cfg_wdata = RW'(d); end
    @(negedge clk) cfg_we = 1'b0;
  endtask

  task automatic coef_write(input int a, input int d);
    @(negedge clk) begin coef_we = 1'b1; coef_addr = AW'(a); coef_wdata = DW'(d); end
    @(negedge clk) coef_we = 1'b0;
  endtask

  task automatic pulse_req();
    @(negedge clk) ramp_req = 1'b1;
    @(negedge clk) ramp_req = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic strobe(output logic d1, output logic d2);
    @(negedge clk) smp_stb = 1'b1;
    @(negedge clk) begin smp_stb = 1'b0; d1 = done; end
    @(negedge clk) d2 = done;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic d1, d2, seen;
    int cnt;
    rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    coef_we = 1'b0; coef_addr = '0; coef_wdata = '0;
    smp_stb = 1'b0; ramp_req = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 gain", int'(gain), UNITY);

    for (int i = 0; i < 16; i++) begin
      coef_m[i] = i * 3001 + 5;
      coef_write(i, coef_m[i]);
    end

    // R3: enable clear, request ignored
    pulse_req();
    chk("R3 busy when off", int'(busy), 0);
    chk("R3 gain when off", int'(gain), UNITY);

    // Table-driven full ramps
    for (int r = 0; r < 5; r++) begin
      cfg_write(2'd1, ROWS[r][1]);
      cfg_write(2'd2, ROWS[r][2]);
      cfg_write(2'd3, ROWS[r][3]);
      cfg_write(2'd0, (ROWS[r][0] << 1) | 1);
      build(ROWS[r][0], ROWS[r][1], ROWS[r][2], ROWS[r][3]);
      pulse_req();
      chk("R4 busy after request", int'(busy), 1);
      chk("R2 first down point", int'(gain), exp_q[0]);
      cnt = 0;
      for (int k = 1; k <= 40; k++) begin
        strobe(d1, d2);
        cnt = k;
        chk(ROWS[r][0] != 0 ? "R8 step gain" : "R5 step gain", int'(gain), exp_q[k]);
        if (d1) begin
          chk("R6 done width", int'(d2), 0);
          chk("R6 busy after done", int'(busy), 0);
          break;
        end
      end
      chk(ROWS[r][2] == 0 ? "R7 strobe count" : "R6 strobe count", cnt, ROWS[r][4]);
    end

    // R9: request mid-ramp ignored
    cfg_write(2'd1, 3);
    cfg_write(2'd2, 0);
    cfg_write(2'd3, 0);
    cfg_write(2'd0, 1);
    pulse_req();
    strobe(d1, d2);
    strobe(d1, d2);
    chk("R9 before extra request", int'(gain), coef_m[1]);
    pulse_req();
    chk("R9 gain after extra request", int'(gain), coef_m[1]);
    chk("R9 busy after extra request", int'(busy), 1);
    strobe(d1, d2);
    chk("R9 next step", int'(gain), coef_m[0]);

    // R11: config write mid-ramp does not affect the current ramp
    cfg_write(2'd1, 1);
    strobe(d1, d2);
    chk("R11 up start", int'(gain), coef_m[0]);
    strobe(d1, d2);
    strobe(d1, d2);
    strobe(d1, d2);
    chk("R11 old up length kept", int'(gain), coef_m[3]);
    strobe(d1, d2);
    chk("R6 done at end", int'(d1), 1);
    chk("R6 unity at end", int'(gain), UNITY);

    // R10 and R11: new request uses new length, no strobe means no move
    pulse_req();
    chk("R11 new down length", int'(gain), coef_m[1]);
    repeat (20) @(negedge clk);
    chk("R10 gain holds", int'(gain), coef_m[1]);
    chk("R10 busy holds", int'(busy), 1);

    // R3: abort by clearing enable
    seen = 1'b0;
    @(negedge clk) begin cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = '0; end
    @(negedge clk) cfg_we = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      seen = seen | done;
    end
    chk("R3 abort busy", int'(busy), 0);
    chk("R3 abort gain", int'(gain), UNITY);
    chk("R3 abort no done", int'(seen), 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule